// File: doc/BRIEF.md
# Serial Audio Port Transmitter

This block sends a stereo stream of sample pairs out over a three-wire serial audio link: a frame clock that marks left and right halves, a bit clock, and one data line. Everything runs from a single master clock. As clock master, the block divides that clock down to make both link clocks. As clock slave, it follows a bit clock and a frame clock that another device drives, resynchronising them into its own clock domain.

Four settings shape the link. An optional halving stage slows the master clock by two. A ratio field gives 128, 192, 256 or 384 master-clock periods per frame. A role bit picks master or slave. A three-bit format code picks I2S, left-justified, or right-justified framing at 16, 18, 20 or 24 bits. Samples arrive as 24-bit words aligned to the MSB, one left/right pair per frame, through a one-cycle ready strobe. The settings are meant to be held steady while the block is out of reset.

Top module: `sap_tx`

## Requirements
- R1: One clock after a synchronous reset: `sclk_out` is 0, `sdata_out` is 0 and `smp_ready` is 0. `lrck_out` shows the right-channel level of the selected format, and `clk_drive_en` equals `cfg_master`.
- R2: In master mode (`cfg_master`=1), `sclk_out` has a period of D master ticks, where D is 2, 3, 4 or 6 for `cfg_ratio` 00, 01, 10 or 11. Counted from a falling edge, it stays low for floor(D/2) ticks and high for the rest. One frame spans 64 bit-clock periods.
- R3: With `cfg_halve`=0 every clock cycle is a master tick. With `cfg_halve`=1 only every second cycle is one, counting from reset, so all master-mode timing stretches by two.
- R4: The frame clock changes only together with a falling edge of the bit clock, and every 32 bit periods. The left channel is frame-clock low for format 000 and frame-clock high for every other code. The first channel after reset is the left one.
- R5: Format 000 (I2S): bit slot 0 of each channel is 0, slots 1..24 carry sample bits 23 down to 0, and slots 25..31 are 0. The data line changes only on bit-clock falling edges.
- R6: Format 001 (left-justified): slots 0..23 carry sample bits 23 down to 0, and slots 24..31 are 0.
- R7: Right-justified codes 011, 101, 110 and 100 send the upper 16, 18, 20 or 24 sample bits, MSB first, with the last bit in slot 31. The slots before them are 0.
- R8: Reserved codes 010 and 111 hold `sdata_out` at 0, while the bit and frame clocks keep running unchanged.
- R9: `smp_ready` is high for exactly the one cycle before the clock edge that opens a left channel. If `smp_valid` is high in that cycle, the pair on `smp_left`/`smp_right` is sent in that frame. If not, the pair sent before is sent again. The pair held after reset is all zeros.
- R10: In slave mode, `clk_drive_en`, `sclk_out` and `lrck_out` are 0. Each channel restarts at slot 0 when the external frame clock changes level. `sdata_out` settles within three clock cycles after the external bit clock falls. Each external bit-clock phase must last at least four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_halve | input | 1 | Halve the master clock before use |
| cfg_ratio | input | 2 | Master clocks per frame: 128/192/256/384 |
| cfg_master | input | 1 | 1 = generate link clocks, 0 = follow external ones |
| cfg_fmt | input | 3 | Framing format code |
| smp_left | input | 24 | Left sample, MSB aligned |
| smp_right | input | 24 | Right sample, MSB aligned |
| smp_valid | input | 1 | A new sample pair is offered |
| smp_ready | output | 1 | Pair taken this cycle if offered |
| sclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External frame clock (slave mode) |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated frame clock (master mode) |
| clk_drive_en | output | 1 | High when the link clocks are driven by this block |
| sdata_out | output | 1 | Serial data, stable at bit-clock rising edges |

## Verification
If the bit-slot counter or channel state goes wrong, the error reaches `sdata_out` at the next bit-clock falling edge. In master mode it also appears as a frame-clock edge in the wrong place within 32 bit periods. A wrong divider state shows up within one bit-clock period as a bit clock with the wrong length or duty. A stale or early sample capture first affects the data line at slot 0 or 1 of the next left channel, and `smp_ready` strobes away from the frame boundary in the very cycle they occur.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SLOT_N   = 32;
    localparam int SLOT_W   = $clog2(SLOT_N);
    localparam int DIV_W    = 3;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'b000,
        FMT_LJ    = 3'b001,
        FMT_RSV_A = 3'b010,
        FMT_RJ16  = 3'b011,
        FMT_RJ24  = 3'b100,
        FMT_RJ18  = 3'b101,
        FMT_RJ20  = 3'b110,
        FMT_RSV_B = 3'b111
    } fmt_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    typedef struct packed {
        logic              used;
        logic [SLOT_W-1:0] first;
        logic [SLOT_W:0]   len;
    } place_t;

    function automatic place_t slot_place(fmt_e f);
        place_t p;
        p.used  = 1'b1;
        p.len   = (SLOT_W+1)'(SAMPLE_W);
        p.first = '0;
        case (f)
            FMT_I2S:  p.first = SLOT_W'(1);
            FMT_LJ:   p.first = '0;
            FMT_RJ16: begin p.len = (SLOT_W+1)'(16); p.first = SLOT_W'(SLOT_N-16); end
            FMT_RJ18: begin p.len = (SLOT_W+1)'(18); p.first = SLOT_W'(SLOT_N-18); end
            FMT_RJ20: begin p.len = (SLOT_W+1)'(20); p.first = SLOT_W'(SLOT_N-20); end
            FMT_RJ24: p.first = SLOT_W'(SLOT_N-SAMPLE_W);
            default:  begin p.used = 1'b0; p.len = '0; end
        endcase
        return p;
    endfunction

    function automatic logic [DIV_W-1:0] sclk_div(logic [1:0] ratio);
        case (ratio)
            2'b00:   return DIV_W'(2);
            2'b01:   return DIV_W'(3);
            2'b10:   return DIV_W'(4);
            default: return DIV_W'(6);
        endcase
    endfunction

    function automatic logic frame_level(fmt_e f, chan_e c);
        return (f == FMT_I2S) ? (c == CH_RIGHT) : (c == CH_LEFT);
    endfunction

    function automatic chan_e level_chan(fmt_e f, logic lvl);
        return ((f == FMT_I2S) ? lvl : ~lvl) ? CH_RIGHT : CH_LEFT;
    endfunction

    function automatic logic fmt_reserved(fmt_e f);
        return (f == FMT_RSV_A) || (f == FMT_RSV_B);
    endfunction

endpackage

// File: rtl/sap_mclk_div.sv
module sap_mclk_div
    import sap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       halve,
    input  logic [1:0] ratio,
    output logic       sclk,
    output logic       fall
);
    logic             tog;
    logic             tick;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] cnt_inc;

    assign div     = sclk_div(ratio);
    assign tick    = halve ? tog : 1'b1;
    assign cnt_inc = DIV_W'(cnt + DIV_W'(1));
    assign fall    = en && tick && (cnt >= DIV_W'(div - DIV_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            tog  <= 1'b0;
            cnt  <= '0;
            sclk <= 1'b0;
        end else begin
            tog <= ~tog;
            if (en && tick) begin
                if (fall) begin
                    cnt  <= '0;
                    sclk <= 1'b0;
                end else begin
                    cnt  <= cnt_inc;
                    sclk <= (cnt_inc >= (div >> 1));
                end
            end
        end
    end

    AST_SCLK_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !(en && tick) |=> $stable(sclk)); // R3

    AST_SCLK_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        fall |=> !sclk); // R2

endmodule

// File: rtl/sap_slave_sync.sv
module sap_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic lrck_in,
    output logic fall,
    output logic lrck_lvl
);
    logic [STAGES-1:0] sclk_sr;
    logic [STAGES-1:0] lrck_sr;
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr   <= '0;
            lrck_sr   <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sr   <= {sclk_sr[STAGES-2:0], sclk_in};
            lrck_sr   <= {lrck_sr[STAGES-2:0], lrck_in};
            sclk_prev <= sclk_sr[STAGES-1];
        end
    end

    assign fall     = sclk_prev & ~sclk_sr[STAGES-1];
    assign lrck_lvl = lrck_sr[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R10

endmodule

// File: rtl/sap_serializer.sv
module sap_serializer
    import sap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fmt_e                fmt,
    input  logic                master,
    input  logic                adv,
    input  logic                ext_lrck,
    input  pair_t               pair_in,
    input  logic                pair_valid,
    output logic                pair_ready,
    output logic                lrck,
    output logic                sdata
);
    chan_e             chan_q, chan_n, chan_ext;
    logic [SLOT_W-1:0] slot_q, slot_n;
    pair_t             held_q, pair_use;
    logic              accept;
    logic              bit_n;
    logic [SAMPLE_W-1:0] word;
    place_t            pl;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N-1);

    assign chan_ext = level_chan(fmt, ext_lrck);

    always_comb begin
        chan_n = chan_q;
        slot_n = slot_q;
        if (master) begin
            if (slot_q == LAST_SLOT) begin
                slot_n = '0;
                chan_n = (chan_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
            end else begin
                slot_n = SLOT_W'(slot_q + SLOT_W'(1));
            end
        end else begin
            if (chan_ext != chan_q) begin
                slot_n = '0;
                chan_n = chan_ext;
            end else if (slot_q != LAST_SLOT) begin
                slot_n = SLOT_W'(slot_q + SLOT_W'(1));
            end
        end
    end

    assign pair_ready = adv && (chan_n == CH_LEFT) && (slot_n == '0);
    assign accept     = pair_ready && pair_valid;
    assign pair_use   = accept ? pair_in : held_q;
    assign word       = (chan_n == CH_LEFT) ? pair_use.left : pair_use.right;
    assign pl         = slot_place(fmt);

    always_comb begin
        int off;
        off   = int'(slot_n) - int'(pl.first);
        bit_n = 1'b0;
        if (pl.used && off >= 0 && off < int'(pl.len))
            bit_n = word[SAMPLE_W-1-off];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= CH_RIGHT;
            slot_q <= LAST_SLOT;
            held_q <= '0;
            sdata  <= 1'b0;
        end else if (adv) begin
            chan_q <= chan_n;
            slot_q <= slot_n;
            held_q <= pair_use;
            sdata  <= bit_n;
        end
    end

    assign lrck = frame_level(fmt, chan_q);

    AST_DATA_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(sdata)); // R5

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fmt_reserved(fmt) && fmt_reserved($past(fmt))) |-> !sdata); // R8

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pair_ready |=> !pair_ready); // R9

    AST_ACCEPT_AT_LEFT_START: assert property (@(posedge clk) disable iff (rst)
        accept |=> (chan_q == CH_LEFT && slot_q == '0)); // R9

    AST_MASTER_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (master && $past(master) && adv && slot_q != LAST_SLOT) |=>
            (slot_q == SLOT_W'($past(slot_q) + SLOT_W'(1)))); // R4

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_halve,
    input  logic [1:0]          cfg_ratio,
    input  logic                cfg_master,
    input  logic [2:0]          cfg_fmt,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic                sclk_in,
    input  logic                lrck_in,
    output logic                sclk_out,
    output logic                lrck_out,
    output logic                clk_drive_en,
    output logic                sdata_out
);
    fmt_e  fmt;
    pair_t pair_in;
    logic  m_sclk, m_fall;
    logic  s_fall, s_lrck;
    logic  adv;
    logic  ser_lrck;

    assign fmt     = fmt_e'(cfg_fmt);
    assign pair_in = '{left: smp_left, right: smp_right};

    sap_mclk_div u_div (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg_master),
        .halve (cfg_halve),
        .ratio (cfg_ratio),
        .sclk  (m_sclk),
        .fall  (m_fall)
    );

    sap_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sclk_in  (sclk_in),
        .lrck_in  (lrck_in),
        .fall     (s_fall),
        .lrck_lvl (s_lrck)
    );

    assign adv = cfg_master ? m_fall : s_fall;

    sap_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .fmt        (fmt),
        .master     (cfg_master),
        .adv        (adv),
        .ext_lrck   (s_lrck),
        .pair_in    (pair_in),
        .pair_valid (smp_valid),
        .pair_ready (smp_ready),
        .lrck       (ser_lrck),
        .sdata      (sdata_out)
    );

    assign sclk_out     = cfg_master & m_sclk;
    assign lrck_out     = cfg_master & ser_lrck;
    assign clk_drive_en = cfg_master;

endmodule

// File: tb/sap_tx_tb.sv
module sap_tx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_halve = 1'b0;
    logic [1:0]  cfg_ratio = 2'b00;
    logic        cfg_master = 1'b1;
    logic [2:0]  cfg_fmt = 3'b000;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic        sclk_in = 1'b1;
    logic        lrck_in = 1'b1;
    logic        sclk_out, lrck_out, clk_drive_en, sdata_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    sap_tx u_dut (
        .clk(clk), .rst(rst), .cfg_halve(cfg_halve), .cfg_ratio(cfg_ratio),
        .cfg_master(cfg_master), .cfg_fmt(cfg_fmt), .smp_left(smp_left),
        .smp_right(smp_right), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .sclk_in(sclk_in), .lrck_in(lrck_in), .sclk_out(sclk_out),
        .lrck_out(lrck_out), .clk_drive_en(clk_drive_en), .sdata_out(sdata_out)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic ref_bit(int fmt, int slot, logic [23:0] s);
        int st, n;
        case (fmt)
            0: begin st = 1;  n = 24; end
            1: begin st = 0;  n = 24; end
            3: begin st = 16; n = 16; end
            4: begin st = 8;  n = 24; end
            5: begin st = 14; n = 18; end
            6: begin st = 12; n = 20; end
            default: begin st = 0; n = 0; end
        endcase
        if (n > 0 && slot >= st && slot < st + n) return s[23 - (slot - st)];
        return 1'b0;
    endfunction

    function automatic string data_tag(int fmt);
        case (fmt)
            0: return "R5";
            1: return "R6";
            2, 7: return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic int ratio_div(int r);
        case (r)
            0: return 2;
            1: return 3;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    // behavioural master-mode reference, evaluated once per clock
    bit          mchk = 0;
    bit          m_tog, m_first, m_pend;
    longint      m_ticks;
    int          m_frames;
    logic [23:0] m_hl, m_hr;

    always @(negedge clk) begin
        if (rst) begin
            m_tog = 0; m_ticks = 0; m_frames = 0; m_pend = 0; m_first = 1;
            m_hl = '0; m_hr = '0;
        end else if (mchk) begin
            int d, chan, slot, g, fmt;
            longint falls, nf;
            bit wt, start;
            logic e_sclk, e_lrck, e_sd;
            if (m_pend) begin
                smp_left  = $urandom();
                smp_right = $urandom();
                smp_valid = (m_frames % 3 != 2);
                m_pend = 0;
            end
            fmt   = int'(cfg_fmt);
            d     = ratio_div(int'(cfg_ratio));
            falls = m_ticks / d;
            e_sclk = ((m_ticks % d) >= (d / 2));
            if (falls == 0) begin chan = 1; slot = 31; end
            else begin g = int'((falls - 1) % 64); chan = g / 32; slot = g % 32; end
            e_lrck = (fmt == 0) ? (chan == 1) : (chan == 0);
            e_sd   = (falls == 0) ? 1'b0 : ref_bit(fmt, slot, chan ? m_hr : m_hl);
            wt     = cfg_halve ? m_tog : 1'b1;
            nf     = (m_ticks + wt) / d;
            start  = wt && (nf != falls) && (((nf - 1) % 64) == 0);
            if (m_first) begin
                chk("R1", "reset sclk_out", sclk_out, 1'b0);
                chk("R1", "reset sdata_out", sdata_out, 1'b0);
                chk("R1", "reset lrck_out", lrck_out, (fmt == 0));
                chk("R1", "reset clk_drive_en", clk_drive_en, 1'b1);
                m_first = 0;
            end
            chk(cfg_halve ? "R3" : "R2", "sclk_out", sclk_out, e_sclk);
            chk("R4", "lrck_out", lrck_out, e_lrck);
            chk(data_tag(fmt), "sdata_out", sdata_out, e_sd);
            chk("R9", "smp_ready", smp_ready, start);
            if (start) begin
                if (smp_valid) begin m_hl = smp_left; m_hr = smp_right; end
                m_frames++;
                m_pend = 1;
            end
            m_ticks += wt;
            m_tog = !m_tog;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_master(bit h, int r, int f, int frames);
        mchk = 0;
        cfg_master = 1'b1; cfg_halve = h; cfg_ratio = 2'(r); cfg_fmt = 3'(f);
        smp_left = $urandom(); smp_right = $urandom(); smp_valid = 1'b1;
        do_reset();
        mchk = 1;
        repeat (frames * 64 * ratio_div(r) * (h ? 2 : 1) + 20) @(negedge clk);
        mchk = 0;
    endtask

    task automatic run_slave(int f, int frames);
        logic [23:0] l, r;
        mchk = 0;
        cfg_master = 1'b0; cfg_fmt = 3'(f);
        l = $urandom(); r = $urandom();
        smp_left = l; smp_right = r; smp_valid = 1'b1;
        sclk_in = 1'b1; lrck_in = (f == 0) ? 1'b1 : 1'b0;
        do_reset();
        repeat (8) @(negedge clk);
        for (int fr = 0; fr < frames; fr++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int s = 0; s < 32; s++) begin
                    sclk_in = 1'b0;
                    lrck_in = (f == 0) ? (ch == 1) : (ch == 0);
                    repeat (4) @(negedge clk);
                    chk("R10", "slave sdata_out", sdata_out, ref_bit(f, s, ch ? r : l));
                    chk("R10", "slave sclk_out", sclk_out, 1'b0);
                    chk("R10", "slave lrck_out", lrck_out, 1'b0);
                    chk("R10", "slave clk_drive_en", clk_drive_en, 1'b0);
                    sclk_in = 1'b1;
                    repeat (4) @(negedge clk);
                end
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        run_master(0, 0, 0, 4);   // R1 R2 R4 R5 R9: I2S, 128x
        run_master(1, 1, 1, 4);   // R3 R6: left-justified, 192x, halved
        run_master(0, 2, 3, 4);   // R7: 16-bit right-justified, 256x
        run_master(0, 3, 4, 4);   // R7: 24-bit right-justified, 384x
        run_master(1, 0, 5, 4);   // R3 R7: 18-bit right-justified, halved
        run_master(0, 1, 6, 4);   // R7: 20-bit right-justified, 192x
        run_master(0, 2, 2, 3);   // R8: reserved 010
        run_master(1, 3, 7, 3);   // R8: reserved 111, halved 384x
        run_slave(0, 2);          // R10: I2S follower
        run_slave(6, 2);          // R10: 20-bit right-justified follower
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule